// File: doc/BRIEF.md
# Pointer Register Update Unit

This block holds the 16-bit pointer state of a small microcoded 8-bit processor. That state is the HL pair, the stack pointer, the instruction pointer, a jump-target register, the memory address register and a one-byte memory write buffer. Each clock cycle the microsequencer presents a set of control fields. The fields choose how each pointer changes: it holds, it takes a special alternate value, it takes the result of the shared incrementer/decrementer, or it takes the shared 16-bit bus. A separate 8-bit result from the ALU can also be steered into any half of these registers.

The incrementer and the bus each have a 2-bit source select. One incrementer serves all pointers, so in any cycle only one value is stepped, and every pointer in mode 2 loads that same result. Memory writes are registered. When the write field is set, the strobe, address and data appear at the outputs one cycle later. The address and data are the ones the memory address register and write buffer held before that cycle's updates. The block also keeps the interrupt-enable bit. A clear request acts at once. A set request acts one cycle late.

Every output is a plain registered level and has no handshake, so there is no back-pressure. The memory side must accept a write strobe on the cycle it appears.

Top module: `ptr_update_unit`

## Requirements
- R1: While reset is asserted, and at its first release, HL, SP, IP, MA, the jump register, the write buffer and the interrupt enable read zero, and the write strobe is low.
- R2: The HL and SP mode codes are: 0 and 1 hold the value, 2 loads the incrementer result, and 3 loads the 16-bit bus. The new value is visible after the clock edge.
- R3: The bus select encodes 0 as {B,C}, 1 as {D,E}, 2 as HL and 3 as SP. The bus uses register values from before the edge.
- R4: The incrementer select encodes 0 as IP, 1 as SP, 2 as HL and 3 as MA. The result is source+1, or source−1 when the decrement bit is 1. It wraps modulo 65536.
- R5: IP and MA use the HL/SP codes, except for code 1. With code 1, IP loads the jump register, and MA loads 0xFF in its high byte and the C input in its low byte.
- R6: With the jump-load bit set, the jump register loads the interrupt vector when an interrupt is pending. Otherwise it loads {0x00, instruction byte AND 0x38}. With the bit clear, it holds.
- R7: When the byte-write enable is set, the write select places the ALU byte as follows: 4=H, 5=L, 6=write buffer, 8=IP high, 9=IP low, 10=jump high, 11=jump low, 12=MA high, 13=MA low, 14=SP high, 15=SP low. Selects 0–3 and 7 name registers held outside the block and change nothing here.
- R8: When a byte write and a 16-bit update hit the same register in one cycle, the byte write wins for its half. The other half takes the 16-bit result.
- R9: A write request raises the strobe for exactly the next cycle. During that cycle the address and data show the MA and write-buffer values from before the request cycle's updates.
- R10: The interrupt-clear bit drops the enable at the next edge. The set bit raises it one edge later, unless a clear arrives in that later cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hl_mode | input | 2 | HL update code |
| sp_mode | input | 2 | SP update code |
| ip_mode | input | 2 | IP update code |
| ma_mode | input | 2 | MA update code |
| bus_sel | input | 2 | 16-bit bus source |
| inc_sel | input | 2 | Incrementer source |
| inc_dec | input | 1 | 1 selects decrement |
| j_load | input | 1 | Load the jump register |
| irq_pend | input | 1 | Interrupt pending |
| irq_vec | input | 16 | Interrupt vector |
| instr | input | 8 | Current instruction byte |
| alu_we | input | 1 | Byte-write enable |
| wsel | input | 4 | Byte-write target |
| alu_y | input | 8 | ALU result byte |
| reg_b | input | 8 | B register value |
| reg_c | input | 8 | C register value |
| reg_d | input | 8 | D register value |
| reg_e | input | 8 | E register value |
| mem_wr | input | 1 | Request a memory write |
| ie_clr | input | 1 | Clear interrupt enable |
| ie_set | input | 1 | Set interrupt enable (delayed) |
| hl_out | output | 16 | HL value |
| sp_out | output | 16 | SP value |
| ip_out | output | 16 | IP value |
| j_out | output | 16 | Jump register value |
| ma_out | output | 16 | MA value (read address) |
| wr_stb | output | 1 | Memory write strobe |
| wr_addr | output | 16 | Memory write address |
| wr_data | output | 8 | Memory write data |
| ie_out | output | 1 | Interrupt enable |

## Verification
Each pointer is an output, so a wrong HL, SP, IP, MA or jump value shows up at the first sample after the edge that corrupted it. A wrong value in the write buffer stays hidden until the next write request, and shows on the write data one cycle after that request. A missing or doubled pending-set stage shows on the enable output one cycle early or late. The bench mixes random control words with directed sequences for wrap, override, vector load and high-page addressing, and compares every visible value after each edge.

// File: rtl/ptr_pkg.sv
package ptr_pkg;
  typedef enum logic [1:0] {
    UPD_HOLD = 2'd0,
    UPD_ALT  = 2'd1,
    UPD_INC  = 2'd2,
    UPD_BUS  = 2'd3
  } upd_e;

  typedef enum logic [3:0] {
    WS_B   = 4'h0, WS_C   = 4'h1, WS_D   = 4'h2, WS_E   = 4'h3,
    WS_H   = 4'h4, WS_L   = 4'h5, WS_MW  = 4'h6, WS_A   = 4'h7,
    WS_IPH = 4'h8, WS_IPL = 4'h9, WS_JH  = 4'hA, WS_JL  = 4'hB,
    WS_MAH = 4'hC, WS_MAL = 4'hD, WS_SPH = 4'hE, WS_SPL = 4'hF
  } wsel_e;

  localparam int NPTR  = 4;
  localparam int IX_HL = 0;
  localparam int IX_SP = 1;
  localparam int IX_IP = 2;
  localparam int IX_MA = 3;
endpackage

// File: rtl/ptr_sel4.sv
module ptr_sel4 #(
  parameter int W = 16
) (
  input  logic [1:0]   sel,
  input  logic [W-1:0] in0,
  input  logic [W-1:0] in1,
  input  logic [W-1:0] in2,
  input  logic [W-1:0] in3,
  output logic [W-1:0] y
);
  always_comb begin
    case (sel)
      2'd0:    y = in0;
      2'd1:    y = in1;
      2'd2:    y = in2;
      default: y = in3;
    endcase
  end
endmodule

// File: rtl/ptr_incdec.sv
module ptr_incdec #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic         dec,
  output logic [W-1:0] y
);
  localparam logic [W-1:0] ONE = W'(1);
  assign y = dec ? (a - ONE) : (a + ONE);
endmodule

// File: rtl/ptr_reg.sv
module ptr_reg
  import ptr_pkg::*;
#(
  parameter int DW = 8,
  localparam int AW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode,
  input  logic [AW-1:0] alt_val,
  input  logic [AW-1:0] inc_val,
  input  logic [AW-1:0] bus_val,
  input  logic          hi_we,
  input  logic          lo_we,
  input  logic [DW-1:0] byte_in,
  output logic [AW-1:0] q
);
  logic [AW-1:0] nxt;

  always_comb begin
    case (upd_e'(mode))
      UPD_ALT: nxt = alt_val;
      UPD_INC: nxt = inc_val;
      UPD_BUS: nxt = bus_val;
      default: nxt = q;
    endcase
    // byte writes land after the wide update
    if (hi_we) nxt[AW-1:DW] = byte_in;
    if (lo_we) nxt[DW-1:0]  = byte_in;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end
endmodule

// File: rtl/ptr_update_unit.sv
module ptr_update_unit
  import ptr_pkg::*;
#(
  parameter int DW = 8,
  parameter logic [DW-1:0] RST_MASK = 8'h38,
  localparam int AW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    hl_mode,
  input  logic [1:0]    sp_mode,
  input  logic [1:0]    ip_mode,
  input  logic [1:0]    ma_mode,
  input  logic [1:0]    bus_sel,
  input  logic [1:0]    inc_sel,
  input  logic          inc_dec,
  input  logic          j_load,
  input  logic          irq_pend,
  input  logic [AW-1:0] irq_vec,
  input  logic [DW-1:0] instr,
  input  logic          alu_we,
  input  logic [3:0]    wsel,
  input  logic [DW-1:0] alu_y,
  input  logic [DW-1:0] reg_b,
  input  logic [DW-1:0] reg_c,
  input  logic [DW-1:0] reg_d,
  input  logic [DW-1:0] reg_e,
  input  logic          mem_wr,
  input  logic          ie_clr,
  input  logic          ie_set,
  output logic [AW-1:0] hl_out,
  output logic [AW-1:0] sp_out,
  output logic [AW-1:0] ip_out,
  output logic [AW-1:0] j_out,
  output logic [AW-1:0] ma_out,
  output logic          wr_stb,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          ie_out
);
  localparam logic [DW-1:0] PAGE_HI = '1;

  logic [AW-1:0] ptr_q   [NPTR];
  logic [AW-1:0] alt_v   [NPTR];
  logic [1:0]    mode_v  [NPTR];
  logic [NPTR-1:0] hi_we, lo_we;
  logic          mw_we, jh_we, jl_we;
  logic [AW-1:0] inc_src, inc_res, bus_val;
  logic [AW-1:0] j_q, j_n;
  logic [DW-1:0] mw_q;
  logic          ie_q, ie_pend_q;

  ptr_sel4 #(.W(AW)) u_inc_mux (
    .sel(inc_sel), .in0(ptr_q[IX_IP]), .in1(ptr_q[IX_SP]),
    .in2(ptr_q[IX_HL]), .in3(ptr_q[IX_MA]), .y(inc_src)
  );

  ptr_incdec #(.W(AW)) u_incdec (.a(inc_src), .dec(inc_dec), .y(inc_res));

  ptr_sel4 #(.W(AW)) u_bus_mux (
    .sel(bus_sel), .in0({reg_b, reg_c}), .in1({reg_d, reg_e}),
    .in2(ptr_q[IX_HL]), .in3(ptr_q[IX_SP]), .y(bus_val)
  );

  // per-pointer mode and alternate value (code 1)
  always_comb begin
    mode_v[IX_HL] = hl_mode;  alt_v[IX_HL] = ptr_q[IX_HL];
    mode_v[IX_SP] = sp_mode;  alt_v[IX_SP] = ptr_q[IX_SP];
    mode_v[IX_IP] = ip_mode;  alt_v[IX_IP] = j_q;
    mode_v[IX_MA] = ma_mode;  alt_v[IX_MA] = {PAGE_HI, reg_c};
  end

  // byte-write target decode
  always_comb begin
    hi_we = '0;
    lo_we = '0;
    mw_we = 1'b0;
    jh_we = 1'b0;
    jl_we = 1'b0;
    if (alu_we) begin
      case (wsel_e'(wsel))
        WS_H:   hi_we[IX_HL] = 1'b1;
        WS_L:   lo_we[IX_HL] = 1'b1;
        WS_MW:  mw_we        = 1'b1;
        WS_IPH: hi_we[IX_IP] = 1'b1;
        WS_IPL: lo_we[IX_IP] = 1'b1;
        WS_JH:  jh_we        = 1'b1;
        WS_JL:  jl_we        = 1'b1;
        WS_MAH: hi_we[IX_MA] = 1'b1;
        WS_MAL: lo_we[IX_MA] = 1'b1;
        WS_SPH: hi_we[IX_SP] = 1'b1;
        WS_SPL: lo_we[IX_SP] = 1'b1;
        default: ;
      endcase
    end
  end

  for (genvar k = 0; k < NPTR; k++) begin : g_ptr
    ptr_reg #(.DW(DW)) u_reg (
      .clk(clk), .rst_n(rst_n), .mode(mode_v[k]), .alt_val(alt_v[k]),
      .inc_val(inc_res), .bus_val(bus_val), .hi_we(hi_we[k]),
      .lo_we(lo_we[k]), .byte_in(alu_y), .q(ptr_q[k])
    );
  end

  always_comb begin
    j_n = j_q;
    if (j_load) j_n = irq_pend ? irq_vec : {{DW{1'b0}}, instr & RST_MASK};
    if (jh_we)  j_n[AW-1:DW] = alu_y;
    if (jl_we)  j_n[DW-1:0]  = alu_y;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      j_q       <= '0;
      mw_q      <= '0;
      ie_q      <= 1'b0;
      ie_pend_q <= 1'b0;
      wr_stb    <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
    end else begin
      j_q       <= j_n;
      if (mw_we) mw_q <= alu_y;
      ie_pend_q <= ie_set;
      if (ie_clr)         ie_q <= 1'b0;
      else if (ie_pend_q) ie_q <= 1'b1;
      wr_stb    <= mem_wr;
      wr_addr   <= ptr_q[IX_MA];
      wr_data   <= mw_q;
    end
  end

  assign hl_out = ptr_q[IX_HL];
  assign sp_out = ptr_q[IX_SP];
  assign ip_out = ptr_q[IX_IP];
  assign ma_out = ptr_q[IX_MA];
  assign j_out  = j_q;
  assign ie_out = ie_q;
endmodule

// File: rtl/ptr_update_checker.sv
module ptr_update_checker #(
  parameter int DW = 8,
  localparam int AW = 2 * DW
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    hl_mode,
  input logic [1:0]    ip_mode,
  input logic [1:0]    ma_mode,
  input logic          alu_we,
  input logic [3:0]    wsel,
  input logic [DW-1:0] reg_c,
  input logic          mem_wr,
  input logic          ie_clr,
  input logic          ie_set,
  input logic [AW-1:0] hl_out,
  input logic [AW-1:0] ip_out,
  input logic [AW-1:0] j_out,
  input logic [AW-1:0] ma_out,
  input logic          wr_stb,
  input logic [AW-1:0] wr_addr,
  input logic          ie_out
);
  logic hl_byte, ip_byte, ma_byte;
  assign hl_byte = alu_we && (wsel == 4'h4 || wsel == 4'h5);
  assign ip_byte = alu_we && (wsel == 4'h8 || wsel == 4'h9);
  assign ma_byte = alu_we && (wsel == 4'hC || wsel == 4'hD);

  assert_stb_raise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |=> wr_stb);
  assert_stb_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_wr |=> !wr_stb);
  assert_wr_addr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |=> wr_addr == $past(ma_out));
  assert_ie_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ie_clr |=> !ie_out);
  assert_ie_delay_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ie_set ##1 !ie_clr) |=> ie_out);
  assert_hl_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!hl_mode[1] && !hl_byte) |=> $stable(hl_out));
  assert_ip_from_j_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ip_mode == 2'd1 && !ip_byte) |=> ip_out == $past(j_out));
  assert_ma_page_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ma_mode == 2'd1 && !ma_byte) |=> ma_out == {{DW{1'b1}}, $past(reg_c)});
endmodule

bind ptr_update_unit ptr_update_checker #(.DW(DW)) i_ptr_chk (
  .clk(clk), .rst_n(rst_n), .hl_mode(hl_mode), .ip_mode(ip_mode),
  .ma_mode(ma_mode), .alu_we(alu_we), .wsel(wsel), .reg_c(reg_c),
  .mem_wr(mem_wr), .ie_clr(ie_clr), .ie_set(ie_set), .hl_out(hl_out),
  .ip_out(ip_out), .j_out(j_out), .ma_out(ma_out), .wr_stb(wr_stb),
  .wr_addr(wr_addr), .ie_out(ie_out)
);

// File: tb/test_ptr_update_unit.sv
`timescale 1ns/1ps
module test_ptr_update_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  hl_mode, sp_mode, ip_mode, ma_mode, bus_sel, inc_sel;
  logic        inc_dec, j_load, irq_pend, alu_we, mem_wr, ie_clr, ie_set;
  logic [15:0] irq_vec;
  logic [7:0]  instr, alu_y, reg_b, reg_c, reg_d, reg_e;
  logic [3:0]  wsel;
  logic [15:0] hl_out, sp_out, ip_out, j_out, ma_out, wr_addr;
  logic        wr_stb, ie_out;
  logic [7:0]  wr_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // model state
  logic [15:0] m_hl, m_sp, m_ip, m_j, m_ma, m_waddr;
  logic [7:0]  m_mw, m_wdata;
  logic        m_ie, m_pend, m_stb;

  always #2 clk = ~clk;

  ptr_update_unit i_ptr_update_unit (
    .clk(clk), .rst_n(rst_n), .hl_mode(hl_mode), .sp_mode(sp_mode),
    .ip_mode(ip_mode), .ma_mode(ma_mode), .bus_sel(bus_sel), .inc_sel(inc_sel),
    .inc_dec(inc_dec), .j_load(j_load), .irq_pend(irq_pend), .irq_vec(irq_vec),
    .instr(instr), .alu_we(alu_we), .wsel(wsel), .alu_y(alu_y), .reg_b(reg_b),
    .reg_c(reg_c), .reg_d(reg_d), .reg_e(reg_e), .mem_wr(mem_wr),
    .ie_clr(ie_clr), .ie_set(ie_set), .hl_out(hl_out), .sp_out(sp_out),
    .ip_out(ip_out), .j_out(j_out), .ma_out(ma_out), .wr_stb(wr_stb),
    .wr_addr(wr_addr), .wr_data(wr_data), .ie_out(ie_out)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] upd(input logic [1:0] m, input logic [15:0] cur,
      input logic [15:0] alt, input logic [15:0] inc, input logic [15:0] bus);
    case (m)
      2'd1:    return alt;
      2'd2:    return inc;
      2'd3:    return bus;
      default: return cur;
    endcase
  endfunction

  task automatic idle();
    hl_mode = 0; sp_mode = 0; ip_mode = 0; ma_mode = 0; bus_sel = 0;
    inc_sel = 0; inc_dec = 0; j_load = 0; irq_pend = 0; irq_vec = 0;
    instr = 0; alu_we = 0; wsel = 0; alu_y = 0; mem_wr = 0;
    ie_clr = 0; ie_set = 0;
  endtask

  task automatic compare_all();
    chk("R2/R3/R4/R7/R8 hl", 32'(hl_out), 32'(m_hl));
    chk("R2/R3/R4/R7/R8 sp", 32'(sp_out), 32'(m_sp));
    chk("R4/R5/R7/R8 ip", 32'(ip_out), 32'(m_ip));
    chk("R4/R5/R7/R8 ma", 32'(ma_out), 32'(m_ma));
    chk("R6/R7 j", 32'(j_out), 32'(m_j));
    chk("R10 ie", 32'(ie_out), 32'(m_ie));
    chk("R9 stb", 32'(wr_stb), 32'(m_stb));
    if (m_stb) begin
      chk("R9 addr", 32'(wr_addr), 32'(m_waddr));
      chk("R7/R9 data", 32'(wr_data), 32'(m_wdata));
    end
  endtask

  // inputs already driven after a negedge; model the edge, then sample
  task automatic tick();
    logic [15:0] src, inc, bus, n_hl, n_sp, n_ip, n_ma, n_j;
    logic [7:0]  n_mw;
    case (inc_sel)
      2'd0: src = m_ip; 2'd1: src = m_sp; 2'd2: src = m_hl; default: src = m_ma;
    endcase
    inc = inc_dec ? src - 16'd1 : src + 16'd1;
    case (bus_sel)
      2'd0: bus = {reg_b, reg_c}; 2'd1: bus = {reg_d, reg_e};
      2'd2: bus = m_hl;           default: bus = m_sp;
    endcase
    n_hl = upd(hl_mode, m_hl, m_hl, inc, bus);
    n_sp = upd(sp_mode, m_sp, m_sp, inc, bus);
    n_ip = upd(ip_mode, m_ip, m_j, inc, bus);
    n_ma = upd(ma_mode, m_ma, {8'hFF, reg_c}, inc, bus);
    n_j  = j_load ? (irq_pend ? irq_vec : {8'h00, instr & 8'h38}) : m_j;
    n_mw = m_mw;
    if (alu_we) begin
      case (wsel)
        4'h4: n_hl[15:8] = alu_y;  4'h5: n_hl[7:0] = alu_y;
        4'h6: n_mw = alu_y;
        4'h8: n_ip[15:8] = alu_y;  4'h9: n_ip[7:0] = alu_y;
        4'hA: n_j[15:8]  = alu_y;  4'hB: n_j[7:0]  = alu_y;
        4'hC: n_ma[15:8] = alu_y;  4'hD: n_ma[7:0] = alu_y;
        4'hE: n_sp[15:8] = alu_y;  4'hF: n_sp[7:0] = alu_y;
        default: ;
      endcase
    end
    m_stb = mem_wr;
    if (mem_wr) begin m_waddr = m_ma; m_wdata = m_mw; end
    if (ie_clr)      m_ie = 1'b0;
    else if (m_pend) m_ie = 1'b1;
    m_pend = ie_set;
    m_hl = n_hl; m_sp = n_sp; m_ip = n_ip; m_ma = n_ma; m_j = n_j; m_mw = n_mw;
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog (all R) actual=timeout expected=finish");
      report();
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    idle();
    reg_b = 8'h12; reg_c = 8'h34; reg_d = 8'h56; reg_e = 8'h78;
    m_hl = 0; m_sp = 0; m_ip = 0; m_j = 0; m_ma = 0; m_mw = 0;
    m_ie = 0; m_pend = 0; m_stb = 0; m_waddr = 0; m_wdata = 0;
    ie_set = 1; mem_wr = 1;        // ignored while in reset
    repeat (3) @(posedge clk);
    @(negedge clk);
    ie_set = 0; mem_wr = 0;
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 ip", 32'(ip_out), 0);  chk("R1 sp", 32'(sp_out), 0);
    chk("R1 ma", 32'(ma_out), 0);  chk("R1 j", 32'(j_out), 0);
    chk("R1 hl", 32'(hl_out), 0);  chk("R1 ie", 32'(ie_out), 0);
    chk("R1 stb", 32'(wr_stb), 0);

    // R4 wrap: SP = FFFF then increment
    alu_we = 1; wsel = 4'hE; alu_y = 8'hFF; tick();
    wsel = 4'hF; tick();
    alu_we = 0; sp_mode = 2; inc_sel = 1; tick();
    chk("R4 wrap up", 32'(sp_out), 32'h0000);
    inc_dec = 1; tick();
    chk("R4 wrap down", 32'(sp_out), 32'hFFFF);
    idle();

    // R8 override: HL from bus DE, high byte replaced
    hl_mode = 3; bus_sel = 1; alu_we = 1; wsel = 4'h4; alu_y = 8'hAB; tick();
    chk("R8 override", 32'(hl_out), 32'hAB78);
    idle();

    // R6 vector and restart target
    j_load = 1; irq_pend = 1; irq_vec = 16'h0040; instr = 8'hFF; tick();
    chk("R6 vector", 32'(j_out), 32'h0040);
    irq_pend = 0; tick();
    chk("R6 restart", 32'(j_out), 32'h0038);
    idle();

    // R5 alternates
    ip_mode = 1; ma_mode = 1; reg_c = 8'h5A; tick();
    chk("R5 ip from j", 32'(ip_out), 32'h0038);
    chk("R5 ma page", 32'(ma_out), 32'hFF5A);
    idle();

    // R7 outside targets have no effect
    alu_we = 1; wsel = 4'h0; alu_y = 8'hEE; tick();
    wsel = 4'h7; tick();
    chk("R7 outside hl", 32'(hl_out), 32'hAB78);
    // R9 write buffer and strobe
    wsel = 4'h6; alu_y = 8'hC3; tick();
    alu_we = 0; mem_wr = 1; ma_mode = 2; inc_sel = 3; tick();
    chk("R9 data", 32'(wr_data), 32'h00C3);
    chk("R9 addr old", 32'(wr_addr), 32'hFF5A);
    idle(); tick();
    chk("R9 single", 32'(wr_stb), 0);

    // R10 delayed set, immediate clear
    ie_set = 1; tick();
    chk("R10 not yet", 32'(ie_out), 0);
    ie_set = 0; tick();
    chk("R10 set", 32'(ie_out), 1);
    ie_clr = 1; tick();
    chk("R10 clear", 32'(ie_out), 0);
    ie_clr = 0; ie_set = 1; tick();
    ie_set = 0; ie_clr = 1; tick();
    chk("R10 clear wins", 32'(ie_out), 0);
    idle();

    // random control words
    for (int i = 0; i < 3000; i++) begin
      hl_mode = 2'($urandom); sp_mode = 2'($urandom);
      ip_mode = 2'($urandom); ma_mode = 2'($urandom);
      bus_sel = 2'($urandom); inc_sel = 2'($urandom); inc_dec = 1'($urandom);
      j_load = ($urandom % 4) == 0; irq_pend = 1'($urandom);
      irq_vec = 16'($urandom); instr = 8'($urandom);
      alu_we = 1'($urandom); wsel = 4'($urandom); alu_y = 8'($urandom);
      reg_b = 8'($urandom); reg_c = 8'($urandom);
      reg_d = 8'($urandom); reg_e = 8'($urandom);
      mem_wr = ($urandom % 3) == 0;
      ie_clr = ($urandom % 8) == 0; ie_set = ($urandom % 6) == 0;
      tick();
    end
    done = 1;
    report();
  end
endmodule